// File: doc/BRIEF.md
# Repeated-Block Majority Voter with Cyclic Code Check

This block receives a serial control field in which one protected block is sent several times in a row. By default there are five copies of a 94-bit block, each made of 80 information bits and a 14-bit cyclic-code suffix. The block resolves every bit position by a 3-of-5 vote across the copies. The vote covers the suffix bits as well as the information bits. It then divides the voted word by the code's generator polynomial to detect errors. The check only flags errors: the word is presented exactly as voted, and nothing is corrected.

Bits arrive one per cycle while `bit_vld` is high, and idle cycles may fall anywhere between them. The first four copies pass through a delay line as they arrive. During the fifth copy, each incoming bit is voted against the matching bit of the four earlier copies, and the voted bit is fed to a serial polynomial divider in the same cycle. The result is therefore ready one clock after the last bit, with no extra processing pass. A start-of-field marker resynchronises the bit count at any time.

Top module: `rep_vote_check`

## Requirements
- R1: A field is COPIES × BLK_W bits (default 5 × 94 = 470). Only cycles with `bit_vld` high count as bits. Within each copy, the first bit received is word bit BLK_W-1 (bit 93) and the last is bit 0.
- R2: Each bit of `word_out` equals the majority value (at least 3 of 5) of the same bit position across the five copies of the field.
- R3: The vote is applied to the suffix positions `word_out[13:0]` in the same way as to the information positions.
- R4: `err` is 1 exactly when the voted word has a nonzero remainder. The word is read as a polynomial with bit 93 as the highest coefficient and is divided by g(x) = x^14 + POLY (default POLY = 14'h0377). `word_out` shows the voted word unchanged even when `err` is 1.
- R5: `done` is high for exactly one clock, in the cycle right after the last bit of a field is accepted. `word_out` and `err` take their new values in that same cycle.
- R6: Between `done` pulses, `word_out` and `err` hold their values, even while a new field is being received.
- R7: A `sof` pulse discards any partial field and sets the bit count to zero. If `bit_vld` is high in the same cycle, that bit is bit 0 of the new field. A discarded partial field never produces `done`.
- R8: After the last bit of a field, the next accepted bit starts a new field without needing `sof`.
- R9: After a synchronous active-low reset, `done`, `err` and `word_out` are all zero and the bit count is zero.
- R10: Idle cycles (`bit_vld` low, `sof` low) leave the result and the field position unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sof | input | 1 | Start-of-field marker, restarts the bit count |
| bit_vld | input | 1 | Qualifies `bit_in` for this cycle |
| bit_in | input | 1 | Serial field data |
| word_out | output | 94 | Voted word, bit 93 first received |
| done | output | 1 | One-cycle pulse when a field completes |
| err | output | 1 | Code check result for `word_out` (1 = nonzero remainder) |

## Verification
Clean fields built from valid codewords show that data lands in the right bit order and that a valid word clears `err`. Fields in which up to two copies are corrupted at any position, suffix included, show that the vote masks minority errors. Fields in which three copies share a flipped bit show that the vote follows the majority and that the check flags the result without repairing it. Random idle gaps, fields sent back to back, and `sof` pulses arriving in the middle of a field (with and without a bit in the same cycle) separate correct bit counting from off-by-one and missing-restart faults, and show that the outputs hold while a new field is being received.

// File: rtl/rvc_pkg.sv
// Package rvc_pkg
// Shared defaults and helpers for the repeated-block voter.
// Assumes nothing beyond IEEE 1800-2017 elaboration.
package rvc_pkg;
    localparam int BLK_W_DEF  = 94;
    localparam int COPIES_DEF = 5;
    localparam int PAR_W_DEF  = 14;
    localparam logic [13:0] POLY_DEF = 14'h0377;

    // Smallest count that wins a vote among n copies.
    function automatic int win_count(input int n);
        return n / 2 + 1;
    endfunction
endpackage

// File: rtl/rvc_delay_line.sv
// Module rvc_delay_line
// Shift register that advances once per accepted bit. It exposes taps that
// delay the input by whole multiples of one block length.
// Assumes: taps are only read after enough bits have been shifted in.
// The line has no reset because its contents are never used earlier.
module rvc_delay_line #(
    parameter int BLK_W = 94,
    parameter int NTAPS = 4
) (
    input  logic             clk,
    input  logic             en,
    input  logic             din,
    output logic [NTAPS-1:0] taps
);
    localparam int DEPTH = BLK_W * NTAPS;

    logic [DEPTH-1:0] line_q;

    // Advance the line on every accepted bit.
    always_ff @(posedge clk) begin
        if (en) begin
            line_q <= {line_q[DEPTH-2:0], din};
        end
    end

    // Tap k delays the input by (k+1) blocks.
    for (genvar k = 0; k < NTAPS; k++) begin : g_tap
        assign taps[k] = line_q[(k + 1) * BLK_W - 1];
    end
endmodule

// File: rtl/rvc_voter.sv
// Module rvc_voter
// Combinational majority vote over N single-bit inputs.
// Assumes N is odd, so a vote can never be tied.
module rvc_voter #(
    parameter int N = 5
) (
    input  logic [N-1:0] votes,
    output logic         maj
);
    import rvc_pkg::*;

    localparam int THR = win_count(N);
    localparam int CW  = $clog2(N + 1);

    logic [CW-1:0] ones;

    // Count the ones and compare the count with the winning threshold.
    always_comb begin
        ones = '0;
        for (int i = 0; i < N; i++) begin
            ones = ones + CW'(votes[i]);
        end
        maj = (ones >= CW'(THR));
    end

    // A unanimous vote must pass through unchanged.
    always_comb begin
        if (&votes) begin
            assert_unanimous_one_R2: assert (maj);
        end
        if (~|votes) begin
            assert_unanimous_zero_R2: assert (!maj);
        end
    end
endmodule

// File: rtl/rvc_poly_div.sv
// Module rvc_poly_div
// Serial polynomial divider that takes the highest coefficient first.
// The remainder register holds the running result. rem_nxt shows the value
// the register will take when the current bit is consumed.
// Assumes: start is raised together with the first bit of each word.
module rvc_poly_div #(
    parameter int           PAR_W = 14,
    parameter logic [PAR_W-1:0] POLY = 14'h0377
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             start,
    input  logic             din,
    output logic [PAR_W-1:0] rem_nxt
);
    logic [PAR_W-1:0] rem_q;
    logic [PAR_W-1:0] base;

    // Shift in one coefficient and reduce when the top coefficient leaves.
    always_comb begin
        base    = start ? '0 : rem_q;
        rem_nxt = {base[PAR_W-2:0], din} ^ (base[PAR_W-1] ? POLY : '0);
    end

    // Hold the running remainder between accepted bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q <= '0;
        end else if (en) begin
            rem_q <= rem_nxt;
        end
    end
endmodule

// File: rtl/rep_vote_check.sv
// Module rep_vote_check (top)
// Receives COPIES serial copies of a BLK_W-bit block and votes each bit
// position across the copies. It then divides the voted word by the code
// generator to detect errors, and presents the word, a done pulse and an
// error flag. Assumes COPIES is odd and at least 3.
module rep_vote_check #(
    parameter int               BLK_W  = rvc_pkg::BLK_W_DEF,
    parameter int               COPIES = rvc_pkg::COPIES_DEF,
    parameter int               PAR_W  = rvc_pkg::PAR_W_DEF,
    parameter logic [PAR_W-1:0] POLY   = rvc_pkg::POLY_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sof,
    input  logic             bit_vld,
    input  logic             bit_in,
    output logic [BLK_W-1:0] word_out,
    output logic             done,
    output logic             err
);
    localparam int TOTAL = BLK_W * COPIES;
    localparam int CW    = $clog2(TOTAL);
    localparam logic [CW-1:0] LAST_S = CW'((COPIES - 1) * BLK_W);
    localparam logic [CW-1:0] FINAL  = CW'(TOTAL - 1);

    logic [CW-1:0]     cnt_q;
    logic [CW-1:0]     pos;
    logic              in_last;
    logic              is_final;
    logic [COPIES-2:0] taps;
    logic              vote;
    logic [PAR_W-1:0]  rem_nxt;
    logic [BLK_W-1:0]  acc_q;
    logic [BLK_W-1:0]  word_q;
    logic              done_q;
    logic              err_q;

    // Field position of the current bit; sof makes it position zero.
    always_comb begin
        pos      = sof ? '0 : cnt_q;
        in_last  = (pos >= LAST_S);
        is_final = (pos == FINAL);
    end

    // Bit counter: wraps after the last bit and restarts on sof.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (bit_vld) begin
            cnt_q <= is_final ? '0 : pos + 1'b1;
        end else if (sof) begin
            cnt_q <= '0;
        end
    end

    rvc_delay_line #(
        .BLK_W (BLK_W),
        .NTAPS (COPIES - 1)
    ) u_line (
        .clk  (clk),
        .en   (bit_vld),
        .din  (bit_in),
        .taps (taps)
    );

    rvc_voter #(
        .N (COPIES)
    ) u_vote (
        .votes ({bit_in, taps}),
        .maj   (vote)
    );

    rvc_poly_div #(
        .PAR_W (PAR_W),
        .POLY  (POLY)
    ) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (bit_vld && in_last),
        .start   (pos == LAST_S),
        .din     (vote),
        .rem_nxt (rem_nxt)
    );

    // Collect voted bits during the final copy, first bit ending up on top.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (bit_vld && in_last) begin
            acc_q <= {acc_q[BLK_W-2:0], vote};
        end
    end

    // Publish word, flag and pulse once the last bit of a field is consumed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
            err_q  <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= bit_vld && is_final;
            if (bit_vld && is_final) begin
                word_q <= {acc_q[BLK_W-2:0], vote};
                err_q  <= |rem_nxt;
            end
        end
    end

    assign word_out = word_q;
    assign err      = err_q;
    assign done     = done_q;

    assert_cnt_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= FINAL);

    assert_done_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_word_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(word_out));

    assert_err_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(err));

    assert_sof_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (sof && !bit_vld) |=> (cnt_q == '0));

    assert_sof_bit_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (sof && bit_vld) |=> (cnt_q == CW'(1)));

    assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!sof && !bit_vld) |=> $stable(cnt_q));
endmodule

// File: tb/rep_vote_check_bench.sv
module rep_vote_check_bench;
    localparam int          W    = 94;
    localparam int          NC   = 5;
    localparam logic [13:0] POLY = 14'h0377;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         sof = 1'b0;
    logic         bit_vld = 1'b0;
    logic         bit_in = 1'b0;
    logic [W-1:0] word_out;
    logic         done;
    logic         err;

    int checks = 0;
    int failures = 0;
    int pulses = 0;
    logic [W-1:0] cp [NC];

    rep_vote_check u_rep_vote_check (
        .clk      (clk),
        .rst_n    (rst_n),
        .sof      (sof),
        .bit_vld  (bit_vld),
        .bit_in   (bit_in),
        .word_out (word_out),
        .done     (done),
        .err      (err)
    );

    always #10 clk = ~clk;

    always @(negedge clk) if (rst_n && done) pulses++;

    task automatic chk(input bit ok, input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Long division of a 94-bit polynomial by x^14 + POLY.
    function automatic logic [13:0] poly_mod(input logic [W-1:0] v);
        logic [14:0] g;
        logic [W-1:0] t;
        g = {1'b1, POLY};
        t = v;
        for (int i = W - 1; i >= 14; i--) begin
            if (t[i]) begin
                for (int j = 0; j < 15; j++) t[i - 14 + j] ^= g[j];
            end
        end
        return t[13:0];
    endfunction

    function automatic logic [W-1:0] make_cw(input logic [79:0] info);
        return {info, poly_mod({info, 14'b0})};
    endfunction

    function automatic logic [79:0] rnd_info();
        return {$urandom(), $urandom(), 16'($urandom())};
    endfunction

    function automatic logic [W-1:0] sparse_mask();
        logic [W-1:0] m = '0;
        for (int i = 0; i < W; i++) if ($urandom_range(0, 9) == 0) m[i] = 1'b1;
        return m;
    endfunction

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            bit_vld = 1'b0;
            sof = 1'b0;
        end
    endtask

    // Send the first nbits of the field held in cp[].
    task automatic send_bits(input int nbits, input bit stall, input bit with_sof);
        int sent = 0;
        for (int k = 0; k < NC; k++) begin
            for (int b = W - 1; b >= 0; b--) begin
                if (sent == nbits) return;
                if (stall && $urandom_range(0, 3) == 0) idle($urandom_range(1, 3));
                @(negedge clk);
                bit_vld = 1'b1;
                bit_in = cp[k][b];
                sof = with_sof && (sent == 0);
                sent++;
            end
        end
    endtask

    // Send a whole field and check the result against the expected word.
    task automatic run_field(input bit stall, input bit with_sof, input logic [W-1:0] exp_w, input string tag);
        int p0 = pulses;
        logic exp_e;
        exp_e = (poly_mod(exp_w) != 14'b0);
        send_bits(NC * W - 1, stall, with_sof);
        @(negedge clk); #1;
        chk(pulses == p0 && done == 1'b0, {tag, " R5 no early done"}, W'(done), '0);
        bit_vld = 1'b1;
        bit_in = cp[NC-1][0];
        sof = 1'b0;
        @(negedge clk);
        bit_vld = 1'b0;
        #1;
        chk(done == 1'b1, {tag, " R5 done after last bit"}, W'(done), W'(1));
        chk(word_out == exp_w, {tag, " word"}, word_out, exp_w);
        chk(err == exp_e, {tag, " R4 err"}, W'(err), W'(exp_e));
        @(negedge clk); #1;
        chk(done == 1'b0 && pulses == p0 + 1, {tag, " R5 single pulse"}, W'(pulses - p0), W'(1));
    endtask

    task automatic fill(input logic [W-1:0] w);
        for (int k = 0; k < NC; k++) cp[k] = w;
    endtask

    initial begin
        #4000000;
        failures++;
        checks++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [W-1:0] cw, cw2, bad, flip, prev_w;
        logic prev_e;
        int a, b2, bp, p0;
        void'($urandom(32'd20240611));
        idle(3);
        @(negedge clk); #1;
        chk(done == 0 && err == 0 && word_out == '0, "R9 reset state", word_out, '0);
        rst_n = 1'b1;

        // R1 clean field with sof on its first bit
        cw = make_cw(rnd_info());
        fill(cw);
        run_field(1'b0, 1'b1, cw, "R1 clean");

        // R8 R10 back to back without sof, with idle gaps
        cw2 = make_cw(rnd_info());
        fill(cw2);
        run_field(1'b1, 1'b0, cw2, "R8 R10 back-to-back");

        // R2 two copies corrupted at random positions
        cw = make_cw(rnd_info());
        fill(cw);
        cp[0] = cw ^ sparse_mask();
        cp[3] = cw ^ sparse_mask();
        run_field(1'b1, 1'b1, cw, "R2 two bad copies");

        // R3 suffix corrupted in two copies
        fill(cw);
        cp[1] = cw ^ W'(14'h3FFF);
        cp[4] = cw ^ W'(14'h2AAA);
        run_field(1'b0, 1'b0, cw, "R3 suffix minority");

        // R2 R4 three copies share a flipped information bit
        flip = W'(1) << 50;
        fill(cw);
        cp[0] = cw ^ flip; cp[2] = cw ^ flip; cp[4] = cw ^ flip;
        run_field(1'b0, 1'b1, cw ^ flip, "R2 R4 majority flip info");

        // R3 R4 three copies share a flipped suffix bit
        flip = W'(1) << 3;
        fill(cw);
        cp[1] = cw ^ flip; cp[2] = cw ^ flip; cp[3] = cw ^ flip;
        run_field(1'b1, 1'b0, cw ^ flip, "R3 R4 majority flip suffix");

        // R4 non-codeword sent clean
        bad = make_cw(rnd_info()) ^ (W'(1) << 93);
        fill(bad);
        run_field(1'b0, 1'b1, bad, "R4 invalid word");

        // R6 outputs hold during a partial field; R7 sof discards it
        prev_w = word_out; prev_e = err; p0 = pulses;
        cw = make_cw(rnd_info());
        fill(~cw);
        send_bits(400, 1'b1, 1'b0);
        idle(1); #1;
        chk(word_out == prev_w && err == prev_e && pulses == p0, "R6 hold during partial", word_out, prev_w);
        fill(cw);
        run_field(1'b1, 1'b1, cw, "R7 sof with bit");

        // R7 sof alone, then field without sof
        fill(~cw);
        send_bits(250, 1'b0, 1'b0);
        @(negedge clk); bit_vld = 1'b0; sof = 1'b1;
        @(negedge clk); sof = 1'b0;
        cw2 = make_cw(rnd_info());
        fill(cw2);
        run_field(1'b0, 1'b0, cw2, "R7 sof alone");

        // Random fields with minority corruption
        for (int n = 0; n < 16; n++) begin
            cw = make_cw(rnd_info());
            fill(cw);
            a = $urandom_range(0, NC - 1);
            b2 = (a + $urandom_range(1, NC - 1)) % NC;
            cp[a] = cw ^ sparse_mask();
            cp[b2] = cw ^ sparse_mask();
            if (n % 4 == 3) begin
                bp = $urandom_range(0, W - 1);
                for (int k = 0; k < 3; k++) cp[(a + k) % NC][bp] = ~cw[bp];
                for (int k = 3; k < NC; k++) cp[(a + k) % NC][bp] = cw[bp];
                cw[bp] = ~cw[bp];
            end
            run_field(n[0], n[1], cw, "R2 random");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule